// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous memory whose write protocol is "late": the address and control of a write are taken on one rising clock edge and the data for that write on the following rising edge. The captured write goes into a one-entry buffer that records the address, the data and which byte lanes were enabled. It reaches the storage array only when the data of the next write arrives. Reads take their address on a rising edge and drive data from the falling edge of that same cycle. Read data is merged lane by lane with the pending buffered write, so a read always returns the most recently written bytes.

The data bus is split into an input bus, an output bus and an output-enable strobe, which a pad ring or an on-chip bus would combine. A sleep input freezes all activity and keeps the contents. A mode input selects between the full address space and a half-size space in which the top address bit is ignored. After sleep ends, and after any change of the mode input, the core enforces a recovery window in which accesses are refused and flagged.

Top module: `lwsram_core`

## Requirements
- R1: At a rising edge with sleep low, `sel_n`=0 and `wr_n`=1 is a read, `sel_n`=0 and `wr_n`=0 is a write, and `sel_n`=1 is a deselect that changes nothing and drives nothing.
- R2: After a read accepted at a rising edge, `doe` is 1 and `dout` carries the word from the falling edge of that cycle until the next rising edge, and stays high through back-to-back reads.
- R3: Write data is taken from `din` at the rising edge one cycle after the write address. The value on `din` during the address cycle is not stored.
- R4: `bwe_n[b]`=0 enables byte lane b, which is bits [8b+7:8b] of the data bus. A write with all `bwe_n` high is an abort and changes no stored byte.
- R5: A read of the address held in the write buffer returns the buffered bytes for enabled lanes and the stored bytes for the other lanes. This includes a read whose address edge is the same edge that captures that write's data.
- R6: The buffered write is committed to the array when the data of the next write is captured, so back-to-back writes to all addresses are all retained.
- R7: `doe` is 0 after reset, in cycles following a write or deselect, and immediately whenever `sleep` is 1.
- R8: While `sleep` is 1, reads and writes are ignored and memory and buffer contents are kept. No error is flagged.
- R9: After `sleep` falls, the first SLEEP_RECOV (default 4) rising edges refuse accesses. The next edge accepts them.
- R10: With `mode_full`=1 all AW address bits are used. With `mode_full`=0 the top address bit is treated as 0.
- R11: The rising edge at which a change of `mode_full` is first seen, and the MODE_RECOV (default 32) edges after it, refuse accesses.
- R12: `proto_err` is 1 for exactly the cycle after each edge at which a read or write was refused by a recovery window, and 0 otherwise (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control on rising edge, read data on falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Power-down request; freezes all access |
| mode_full | input | 1 | 1: full address space; 0: top address bit ignored |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | 0 = write, 1 = read when selected |
| bwe_n | input | NB (4) | Active-low byte lane enables |
| addr | input | AW (6) | Word address |
| din | input | NB*BW (32) | Write data, one cycle after its address |
| dout | output | NB*BW (32) | Read data |
| doe | output | 1 | Output enable for `dout` |
| proto_err | output | 1 | Pulse: access refused during a recovery window |

## Verification
The hardest case to reach is a read whose address edge coincides with the edge that loads a partially enabled write into the buffer. In that cycle the output must mix freshly buffered lanes with lanes that were committed only on that same edge. The bench gets there by writing one address under every one of the sixteen lane-enable patterns, each followed at once by a read of the same word, and compares every result with a lane-by-lane model. The recovery windows are probed edge by edge: a read is offered on every edge after sleep ends and after each mode flip, and the exact count of refused edges is checked.

// File: rtl/lwsram_pkg.sv
// Shared types for the late-write SRAM core.
package lwsram_pkg;

    // Operation requested at a rising edge after select/sleep decode.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/lwsram_ctrl.sv
// Control front end: decodes select/write-enable at each rising edge,
// applies the half-space address mask, and runs the recovery guard that
// refuses accesses after sleep or a mode change.
// Assumes: sleep is already stable around the rising edge it is sampled on.
module lwsram_ctrl
    import lwsram_pkg::*;
#(
    parameter int AW          = 6,
    parameter int NB          = 4,
    parameter int SLEEP_RECOV = 4,
    parameter int MODE_RECOV  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep,
    input  logic          mode_full,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic [NB-1:0] bwe_n,
    input  logic [AW-1:0] addr,
    output logic          rd_q,
    output logic [AW-1:0] rd_addr_q,
    output logic          wr_pend_q,
    output logic          wr_take,
    output logic [AW-1:0] wr_addr_q,
    output logic [NB-1:0] wr_mask_q,
    output logic          proto_err
);

    localparam int MAXR = (SLEEP_RECOV > MODE_RECOV) ? SLEEP_RECOV : MODE_RECOV;
    localparam int CW   = $clog2(MAXR + 1);
    localparam logic [AW-1:0] HALF_MASK = {1'b0, {(AW-1){1'b1}}};

    op_e           op_now;
    logic          mode_q;
    logic [CW-1:0] guard_cnt;
    logic          blocked;
    logic [AW-1:0] eff_addr;

    // Decode the requested operation for this edge.
    always_comb begin
        if (sleep || sel_n)
            op_now = OP_IDLE;
        else if (wr_n)
            op_now = OP_READ;
        else
            op_now = OP_WRITE;
    end

    // Refuse accesses while a recovery window runs or a mode change is seen.
    assign blocked  = (guard_cnt != '0) || (mode_full != mode_q);
    // Half-space mode clears the top address bit.
    assign eff_addr = mode_q ? addr : (addr & HALF_MASK);

    // Recovery guard: reload on sleep or mode change, count down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= mode_full;
            guard_cnt <= '0;
        end else if (sleep) begin
            guard_cnt <= CW'(SLEEP_RECOV);
        end else if (mode_full != mode_q) begin
            mode_q    <= mode_full;
            guard_cnt <= CW'(MODE_RECOV);
        end else if (guard_cnt != '0) begin
            guard_cnt <= guard_cnt - 1'b1;
        end
    end

    // Register accepted operations, their addresses and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            wr_pend_q <= 1'b0;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            wr_mask_q <= '0;
            proto_err <= 1'b0;
        end else begin
            rd_q      <= (op_now == OP_READ)  && !blocked;
            wr_pend_q <= (op_now == OP_WRITE) && !blocked;
            proto_err <= (op_now != OP_IDLE)  && blocked;
            if (op_now == OP_READ && !blocked)
                rd_addr_q <= eff_addr;
            if (op_now == OP_WRITE && !blocked) begin
                wr_addr_q <= eff_addr;
                wr_mask_q <= ~bwe_n;
            end
        end
    end

    // Write data is taken one edge after the address unless sleep is high.
    assign wr_take = wr_pend_q && !sleep;

    // R8: an edge sampled in sleep never yields an accepted operation.
    a_r8_sleep_blocks_ops: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (!rd_q && !wr_pend_q));

    // R12: a flagged edge never also produced an accepted operation.
    a_r12_err_excludes_op: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (!rd_q && !wr_pend_q));

endmodule

// File: rtl/lwsram_wbuf.sv
// One-entry write buffer: holds address, lane mask and data of the most
// recent write; hands the previous entry to the array when new data lands.
// Assumes: take pulses exactly on the data edge of an accepted write.
module lwsram_wbuf #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [AW-1:0]    wr_addr,
    input  logic [NB-1:0]    wr_mask,
    input  logic [NB*BW-1:0] din,
    output logic             buf_valid,
    output logic [AW-1:0]    buf_addr,
    output logic [NB-1:0]    buf_mask,
    output logic [NB*BW-1:0] buf_data,
    output logic             commit
);

    // Old entry drains to the array on the same edge the new one loads.
    assign commit = take && buf_valid;

    // Load the buffer with the data phase of the newest write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_addr  <= '0;
            buf_mask  <= '0;
            buf_data  <= '0;
        end else if (take) begin
            buf_valid <= 1'b1;
            buf_addr  <= wr_addr;
            buf_mask  <= wr_mask;
            buf_data  <= din;
        end
    end

    // R6: the buffer becomes valid only through a write data phase.
    a_r6_fill_from_take: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_valid) |-> $past(take));

endmodule

// File: rtl/lwsram_array.sv
// Storage array, one memory per byte lane so lanes write independently.
// Asynchronous read; write on rising edge when the buffer commits.
// Assumes: contents are not reset; readers only use written words.
module lwsram_array #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             commit,
    input  logic [AW-1:0]    waddr,
    input  logic [NB-1:0]    wmask,
    input  logic [NB*BW-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [NB*BW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < NB; l++) begin : g_lane
        logic [BW-1:0] lane_mem [DEPTH];

        // Commit this lane when its mask bit was enabled.
        always_ff @(posedge clk) begin
            if (commit && wmask[l])
                lane_mem[waddr] <= wdata[l*BW +: BW];
        end

        assign rdata[l*BW +: BW] = lane_mem[raddr];
    end

endmodule

// File: rtl/lwsram_rdpath.sv
// Read path: merges array data with the write buffer per lane and latches
// the result on the falling edge of the read cycle; gates the output enable.
// Assumes: rd_q and rd_addr are stable from one rising edge to the next.
module lwsram_rdpath #(
    parameter int AW = 6,
    parameter int NB = 4,
    parameter int BW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             rd_q,
    input  logic [AW-1:0]    rd_addr,
    input  logic [NB*BW-1:0] mem_rdata,
    input  logic             buf_valid,
    input  logic [AW-1:0]    buf_addr,
    input  logic [NB-1:0]    buf_mask,
    input  logic [NB*BW-1:0] buf_data,
    output logic [NB*BW-1:0] dout,
    output logic             doe
);

    logic [NB*BW-1:0] merged;
    logic             addr_hit;
    logic             doe_q;

    assign addr_hit = buf_valid && (buf_addr == rd_addr);

    for (genvar l = 0; l < NB; l++) begin : g_merge
        // Buffered lane wins over the array lane.
        assign merged[l*BW +: BW] = (addr_hit && buf_mask[l]) ?
                                    buf_data[l*BW +: BW] : mem_rdata[l*BW +: BW];
    end

    // Falling-edge output register for the read cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            doe_q <= 1'b0;
            dout  <= '0;
        end else begin
            doe_q <= rd_q;
            if (rd_q)
                dout <= merged;
        end
    end

    // Output enabled from the falling edge until the read cycle ends.
    assign doe = doe_q && rd_q && !sleep;

endmodule

// File: rtl/lwsram_core.sv
// Late-write synchronous SRAM core: control front end, one-entry write
// buffer, lane-split storage array and falling-edge read path.
// Assumes: split data bus (din/dout/doe) combined outside this block.
module lwsram_core #(
    parameter int AW          = 6,
    parameter int NB          = 4,
    parameter int BW          = 8,
    parameter int SLEEP_RECOV = 4,
    parameter int MODE_RECOV  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             mode_full,
    input  logic             sel_n,
    input  logic             wr_n,
    input  logic [NB-1:0]    bwe_n,
    input  logic [AW-1:0]    addr,
    input  logic [NB*BW-1:0] din,
    output logic [NB*BW-1:0] dout,
    output logic             doe,
    output logic             proto_err
);

    localparam int DW = NB * BW;

    logic          rd_q;
    logic [AW-1:0] rd_addr_q;
    logic          wr_pend_q;
    logic          wr_take;
    logic [AW-1:0] wr_addr_q;
    logic [NB-1:0] wr_mask_q;
    logic          buf_valid;
    logic [AW-1:0] buf_addr;
    logic [NB-1:0] buf_mask;
    logic [DW-1:0] buf_data;
    logic          commit;
    logic [DW-1:0] mem_rdata;

    lwsram_ctrl #(
        .AW(AW), .NB(NB), .SLEEP_RECOV(SLEEP_RECOV), .MODE_RECOV(MODE_RECOV)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .mode_full(mode_full),
        .sel_n(sel_n), .wr_n(wr_n), .bwe_n(bwe_n), .addr(addr),
        .rd_q(rd_q), .rd_addr_q(rd_addr_q), .wr_pend_q(wr_pend_q),
        .wr_take(wr_take), .wr_addr_q(wr_addr_q), .wr_mask_q(wr_mask_q),
        .proto_err(proto_err)
    );

    lwsram_wbuf #(.AW(AW), .NB(NB), .BW(BW)) wbuf_i (
        .clk(clk), .rst_n(rst_n), .take(wr_take),
        .wr_addr(wr_addr_q), .wr_mask(wr_mask_q), .din(din),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_mask(buf_mask),
        .buf_data(buf_data), .commit(commit)
    );

    lwsram_array #(.AW(AW), .NB(NB), .BW(BW)) array_i (
        .clk(clk), .commit(commit), .waddr(buf_addr), .wmask(buf_mask),
        .wdata(buf_data), .raddr(rd_addr_q), .rdata(mem_rdata)
    );

    lwsram_rdpath #(.AW(AW), .NB(NB), .BW(BW)) rdpath_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .rd_q(rd_q),
        .rd_addr(rd_addr_q), .mem_rdata(mem_rdata), .buf_valid(buf_valid),
        .buf_addr(buf_addr), .buf_mask(buf_mask), .buf_data(buf_data),
        .dout(dout), .doe(doe)
    );

    // R2: the output is enabled only in the cycle after a read request.
    a_r2_oe_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> $past(!sel_n && wr_n && !sleep));

    // R7: a write request edge is never followed by an enabled output.
    a_r7_no_oe_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && !wr_n) |=> !doe);

    // R3: write data phase always follows an accepted write address.
    a_r3_take_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> $past(!sel_n && !wr_n && !sleep));

endmodule

// File: tb/lwsram_core_tb_top.sv
module lwsram_core_tb_top;

    localparam int AW = 6, NB = 4, BW = 8, DW = 32, SR = 4, MR = 32;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sleep;
    logic          mode_full;
    logic          sel_n;
    logic          wr_n;
    logic [NB-1:0] bwe_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          doe;
    logic          proto_err;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    logic [DW-1:0] model [DEPTH];
    bit            pend_v = 0;
    logic [AW-1:0] pend_a;
    logic [NB-1:0] pend_m;
    logic [DW-1:0] pend_d;
    bit            mode_b = 1;

    always #10 clk = ~clk;

    lwsram_core #(.AW(AW), .NB(NB), .BW(BW), .SLEEP_RECOV(SR), .MODE_RECOV(MR)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .mode_full(mode_full),
        .sel_n(sel_n), .wr_n(wr_n), .bwe_n(bwe_n), .addr(addr), .din(din),
        .dout(dout), .doe(doe), .proto_err(proto_err)
    );

    function automatic logic [AW-1:0] eff(input logic [AW-1:0] a);
        return mode_b ? a : (a & 6'h1F);
    endfunction

    function automatic logic [DW-1:0] wd(input int a, input int k);
        return ((32'(a) + 32'd1) * 32'h01F35A97) ^ (32'(k) << 9) ^ 32'h5A000000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock step; din carries the data of the previous accepted write.
    task automatic step(input logic s_n, input logic w_n, input logic [NB-1:0] b_n,
                        input logic [AW-1:0] a, input bit acc_wr, input logic [DW-1:0] newd);
        sel_n = s_n; wr_n = w_n; bwe_n = b_n; addr = a;
        din   = pend_v ? pend_d : 32'hDEADBEEF;
        @(posedge clk);
        #1;
        if (pend_v) begin
            for (int l = 0; l < NB; l++)
                if (pend_m[l]) model[pend_a][l*BW +: BW] = pend_d[l*BW +: BW];
        end
        pend_v = 0;
        if (acc_wr) begin
            pend_v = 1; pend_a = eff(a); pend_m = ~b_n; pend_d = newd;
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] b_n,
                      input logic [DW-1:0] d, input bit acc, input bit err, input string tag);
        step(1'b0, 1'b0, b_n, a, acc, d);
        chk(proto_err == err, {tag, " R12 flag on write"}, DW'(proto_err), DW'(err));
        chk(doe == 1'b0, {tag, " R7 oe in write cycle"}, DW'(doe), 0);
    endtask

    task automatic rd(input logic [AW-1:0] a, input bit acc, input bit err, input string tag);
        step(1'b0, 1'b1, '1, a, 1'b0, '0);
        chk(proto_err == err, {tag, " R12 flag on read"}, DW'(proto_err), DW'(err));
        #12;
        if (acc) chk(doe === 1'b1 && dout === model[eff(a)], {tag, " R2 read data"},
                     doe ? dout : 32'hXXXXXXXX, model[eff(a)]);
        else     chk(doe === 1'b0, {tag, " refused read drives nothing"}, DW'(doe), 0);
    endtask

    task automatic desel();
        step(1'b1, 1'b1, '1, '0, 1'b0, '0);
        chk(doe == 1'b0 && proto_err == 1'b0, "R1 R7 deselect quiet",
            DW'({doe, proto_err}), 0);
    endtask

    initial begin
        rst_n = 0; sleep = 0; mode_full = 1; sel_n = 1; wr_n = 1;
        bwe_n = '1; addr = '0; din = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(doe == 1'b0 && proto_err == 1'b0, "R7 R12 reset state",
            DW'({doe, proto_err}), 0);
        rst_n = 1;

        // Back-to-back full writes to every address, then read all (R1 R3 R6).
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0, wd(a, 0), 1, 0, "R6 sweep");
        desel();
        for (int a = 0; a < DEPTH; a++) rd(AW'(a), 1, 0, "R3 R6 sweep");
        desel();

        // Every lane-enable pattern, each read back in the data edge (R4 R5).
        for (int m = 0; m < 16; m++) begin
            wr(6'd9, NB'(m), wd(9, m + 100), 1, 0, "R4 lane write");
            rd(6'd9, 1, 0, "R5 buffered merge");
            rd(6'd8, 1, 0, "R4 neighbour untouched");
        end
        desel();
        rd(6'd9, 1, 0, "R4 abort kept word");

        // Interleaved writes and reads of other words (R1 R5 R6).
        for (int i = 0; i < 12; i++) begin
            wr(AW'(i * 5 + 3), '0, wd(i, 7), 1, 0, "R1 interleave");
            rd(AW'(i * 5 + 3), 1, 0, "R5 interleave");
            rd(AW'(i * 5 + 2), 1, 0, "R1 interleave other");
        end

        // Sleep: outputs off, accesses ignored, contents kept (R7 R8 R9).
        wr(6'd20, '0, wd(20, 55), 1, 0, "R8 before sleep");
        desel();
        rd(6'd20, 1, 0, "R8 before sleep");
        sleep = 1;
        #1;
        chk(doe == 1'b0, "R7 sleep kills oe", DW'(doe), 0);
        rd(6'd20, 0, 0, "R8 read in sleep");
        wr(6'd3, '0, 32'h0BAD0BAD, 0, 0, "R8 write in sleep");
        desel();
        sleep = 0;
        for (int k = 0; k < SR; k++) rd(6'd20, 0, 1, "R9 sleep recovery");
        rd(6'd20, 1, 0, "R9 first access after recovery");
        rd(6'd3, 1, 0, "R8 contents kept");
        desel();
        chk(proto_err == 1'b0, "R12 flag single cycle", DW'(proto_err), 0);

        // Mode change to half space (R10 R11).
        mode_full = 0; mode_b = 0;
        for (int k = 0; k < MR + 1; k++) rd(6'h25, 0, 1, "R11 mode window");
        rd(6'h25, 1, 0, "R10 half space alias");
        wr(6'h3A, '0, 32'hC0FFEE11, 1, 0, "R10 half write");
        desel();
        rd(6'h1A, 1, 0, "R10 alias low");
        rd(6'h3A, 1, 0, "R10 alias high");
        desel();

        // Back to full space (R10 R11).
        mode_full = 1; mode_b = 1;
        for (int k = 0; k < MR + 1; k++) rd(6'h3A, 0, 1, "R11 mode window back");
        rd(6'h3A, 1, 0, "R10 full space upper word");
        rd(6'h1A, 1, 0, "R10 full space lower word");
        desel();

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 run did not complete actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule